// File: doc/BRIEF.md
# Masked gather-prefetch address sequencer

This block turns one vector gather-prefetch operation into a stream of single-address prefetch requests. On a start pulse it captures a packed vector of indices, a base address with a flag saying whether a base is present, a scale, a displacement with its width, an element mask and a mode. For each element whose mask bit is set, it forms the address base plus sign-extended index shifted by the scale plus sign-extended displacement. It then issues one request per cycle on a valid/ready port.

The mode selects the index width and the element count. Mode 0 uses 32-bit indices with 16 elements. Mode 1 uses 32-bit indices with 8 elements. Modes 2 and 3 use 64-bit indices with 8 elements. Every request carries a fixed second-level cache hint and a cleared ownership flag. The operation never faults. When the last request has been accepted, the block pulses `done`. The captured mask stays visible, unchanged, on `mask_out`.

Top module: `gpf_prefetch_seq`

## Requirements
- R1: Each request address equals base + (sign-extended index << scale) + sign-extended displacement, computed modulo 2^64; the request never signals a fault for any value.
- R2: `scale_log2` values 0, 1, 2 and 3 multiply the index by 1, 2, 4 and 8.
- R3: `disp_sel` value 0 means there is no displacement (adds zero). Value 1 sign-extends `disp[7:0]`, value 2 sign-extends `disp[15:0]`, and value 3 sign-extends `disp[31:0]`.
- R4: When `base_valid` is 0, the base is treated as zero.
- R5: Mode 0 processes 16 elements, and element j uses `index_vec[32j+31:32j]` as a signed 32-bit index.
- R6: Mode 1 processes 8 elements from the low eight 32-bit index lanes; mask bits 15:8 produce no requests.
- R7: Modes 2 and 3 process 8 elements, and element j uses `index_vec[64j+63:64j]` as a signed 64-bit index; mask bits 15:8 produce no requests.
- R8: A request is issued only for elements whose mask bit is 1, one element per request, in ascending element order.
- R9: While `req_valid` is high and `req_ready` is low, the request is held with its address unchanged.
- R10: Every request has `req_level` = 1 and `req_own` = 0.
- R11: `done` pulses for one cycle, starting in the cycle after the last request is accepted. If no element is enabled, `done` pulses in the cycle after start and no request is issued.
- R12: `mask_out` shows the captured mask, all 16 bits, unchanged by the operation.
- R13: A start pulse while the block is busy is ignored and does not disturb the sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Capture the operands and begin an operation (only when idle) |
| mode | input | 2 | 0: 32-bit idx/16 elems, 1: 32-bit idx/8 elems, 2,3: 64-bit idx/8 elems |
| index_vec | input | 512 | Packed index vector |
| base_addr | input | 64 | Base address |
| base_valid | input | 1 | Base present; 0 means the base is zero |
| scale_log2 | input | 2 | Shift amount applied to the index |
| disp | input | 32 | Displacement |
| disp_sel | input | 2 | Displacement width: none, 8, 16 or 32 bits |
| mask_in | input | 16 | Element enable mask |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Downstream accepts the request |
| req_addr | output | 64 | Prefetch byte address |
| req_level | output | 2 | Cache-level hint (always 1) |
| req_own | output | 1 | Ownership request flag (always 0) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| mask_out | output | 16 | Captured mask, unchanged |

## Verification
The bench builds the block with its default parameters: 64-bit addresses, sixteen 32-bit lanes and a 512-bit index vector. These values expose both the 16-element dword layout and the 8-element qword layout. They also cover the full 64-bit wrap of the address sum, the sign extension of negative 32-bit indices into the upper address half, and the case where mask bits 15:8 are present but must be ignored in the 8-element modes.

// File: rtl/gpf_pkg.sv
// Package: shared mode encoding and constants for the gather-prefetch sequencer.
// Assumes mode values are decoded upstream into the 2-bit code below.
package gpf_pkg;
    typedef enum logic [1:0] {
        GPF_D_SP = 2'd0,   // 32-bit index, 16 elements
        GPF_D_DP = 2'd1,   // 32-bit index, 8 elements
        GPF_Q_SP = 2'd2,   // 64-bit index, 8 elements
        GPF_Q_DP = 2'd3    // 64-bit index, 8 elements
    } gpf_mode_e;

    typedef enum logic [1:0] {
        DSP_NONE = 2'd0,
        DSP_B8   = 2'd1,
        DSP_B16  = 2'd2,
        DSP_B32  = 2'd3
    } gpf_disp_e;

    localparam logic [1:0] GPF_HINT_L2 = 2'd1;
endpackage

// File: rtl/gpf_lane_pick.sv
// Module: selects the index for the current element from the packed vector
// and sign-extends it to the address width. Assumes ADDR_W >= 2*LANE_W and
// LANES is even; 64-bit lanes occupy pairs of 32-bit lanes.
module gpf_lane_pick #(
    parameter int LANES  = 16,
    parameter int LANE_W = 32,
    parameter int ADDR_W = 64,
    localparam int VEC_W = LANES * LANE_W,
    localparam int EW    = $clog2(LANES),
    localparam int WIDE  = LANES / 2
) (
    input  logic [VEC_W-1:0]  idx_vec,
    input  logic [EW-1:0]     elem,
    input  logic              wide_idx,
    output logic [ADDR_W-1:0] idx_ext
);
    logic [ADDR_W-1:0] narrow_arr [LANES];
    logic [ADDR_W-1:0] wide_arr   [WIDE];

    // Sign-extend every narrow lane.
    for (genvar n = 0; n < LANES; n++) begin : g_narrow
        assign narrow_arr[n] = ADDR_W'($signed(idx_vec[n*LANE_W +: LANE_W]));
    end

    // Sign-extend every double-width lane.
    for (genvar w = 0; w < WIDE; w++) begin : g_wide
        assign wide_arr[w] = ADDR_W'($signed(idx_vec[w*2*LANE_W +: 2*LANE_W]));
    end

    // Pick the lane layout given by the mode.
    always_comb begin
        if (wide_idx) idx_ext = wide_arr[elem[EW-2:0]];
        else          idx_ext = narrow_arr[elem];
    end
endmodule

// File: rtl/gpf_addr_calc.sv
// Module: forms base + (index << scale) + displacement. Assumes the index is
// already sign-extended; the sum wraps at ADDR_W bits and never faults.
module gpf_addr_calc
    import gpf_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int DISP_W = 32
) (
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              base_valid,
    input  logic [ADDR_W-1:0] idx_ext,
    input  logic [1:0]        scale_log2,
    input  logic [DISP_W-1:0] disp,
    input  gpf_disp_e         disp_sel,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] disp_ext;
    logic [ADDR_W-1:0] base_eff;
    logic [ADDR_W-1:0] idx_scaled;

    // Sign-extend the displacement at the selected width.
    always_comb begin
        unique case (disp_sel)
            DSP_B8:  disp_ext = ADDR_W'($signed(disp[7:0]));
            DSP_B16: disp_ext = ADDR_W'($signed(disp[15:0]));
            DSP_B32: disp_ext = ADDR_W'($signed(disp[DISP_W-1:0]));
            default: disp_ext = '0;
        endcase
    end

    // An absent base contributes zero; the scale is a shift of 0..3 bits.
    always_comb begin
        base_eff   = base_valid ? base_addr : '0;
        idx_scaled = idx_ext << scale_log2;
        addr       = base_eff + idx_scaled + disp_ext;
    end
endmodule

// File: rtl/gpf_elem_sched.sv
// Module: walks the enabled elements in ascending order, one per accepted
// request, and pulses done after the last one. Assumes the mode is stable
// only at start; the element limit is applied when the mask is captured.
module gpf_elem_sched
    import gpf_pkg::*;
#(
    parameter int LANES = 16,
    localparam int EW   = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  gpf_mode_e        mode,
    input  logic [LANES-1:0] mask_in,
    input  logic             req_ready,
    output logic             launch,
    output logic             req_valid,
    output logic [EW-1:0]    elem,
    output logic             busy,
    output logic             done,
    output logic [LANES-1:0] mask_out
);
    localparam logic [LANES-1:0] ALL_ON  = '1;
    localparam logic [LANES-1:0] HALF_ON = ALL_ON >> (LANES / 2);

    logic [LANES-1:0] pend_q;
    logic [LANES-1:0] mask_q;
    logic [LANES-1:0] grant;
    logic [LANES-1:0] lim;
    logic [LANES-1:0] pend_next;
    logic             busy_q;
    logic             done_q;

    // A new operation starts only from idle.
    assign launch = start && !busy_q;
    // Element count set by the mode: 16 lanes only in mode 0.
    assign lim = (mode == GPF_D_SP) ? ALL_ON : HALF_ON;
    // Lowest pending element wins.
    assign grant = pend_q & (~pend_q + 1'b1);
    assign pend_next = pend_q & ~grant;

    // Encode the granted element number.
    always_comb begin
        elem = '0;
        for (int i = 0; i < LANES; i++) begin
            if (grant[i]) elem = EW'(i);
        end
    end

    // Capture the mask, retire granted elements, raise done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            mask_q <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (launch) begin
                mask_q <= mask_in;
                pend_q <= mask_in & lim;
                busy_q <= |(mask_in & lim);
                done_q <= ~|(mask_in & lim);
            end else if (busy_q && req_ready) begin
                pend_q <= pend_next;
                if (pend_next == '0) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign req_valid = busy_q;
    assign busy      = busy_q;
    assign done      = done_q;
    assign mask_out  = mask_q;

    // R8: at most one element granted at a time.
    p_one_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // R9: a stalled request stays valid on the same element.
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(elem)));
    // R11: the last acceptance is followed by done.
    p_done_after_last_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && $countones(pend_q) == 1) |=> done);
    // R11: done never overlaps a request.
    p_done_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_valid);
    // R12 / R13: the captured mask does not move while busy.
    p_mask_keep_r12: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mask_out));
endmodule

// File: rtl/gpf_prefetch_seq.sv
// Module (top): masked gather-prefetch address sequencer. Captures the
// operands on start, then issues one prefetch request per enabled element.
// Assumes the downstream port follows valid/ready; the hint is fixed.
module gpf_prefetch_seq
    import gpf_pkg::*;
#(
    parameter int LANES  = 16,
    parameter int LANE_W = 32,
    parameter int ADDR_W = 64,
    parameter int DISP_W = 32,
    localparam int VEC_W = LANES * LANE_W,
    localparam int EW    = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        mode,
    input  logic [VEC_W-1:0]  index_vec,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              base_valid,
    input  logic [1:0]        scale_log2,
    input  logic [DISP_W-1:0] disp,
    input  logic [1:0]        disp_sel,
    input  logic [LANES-1:0]  mask_in,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    output logic [1:0]        req_level,
    output logic              req_own,
    output logic              busy,
    output logic              done,
    output logic [LANES-1:0]  mask_out
);
    logic              launch;
    logic [EW-1:0]     elem;
    logic [VEC_W-1:0]  idx_q;
    logic [ADDR_W-1:0] base_q;
    logic              bv_q;
    logic [1:0]        sc_q;
    logic [DISP_W-1:0] disp_q;
    gpf_disp_e         dsel_q;
    gpf_mode_e         mode_q;
    logic [ADDR_W-1:0] idx_ext;

    // Hold the operands for the whole operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            base_q <= '0;
            bv_q   <= 1'b0;
            sc_q   <= '0;
            disp_q <= '0;
            dsel_q <= DSP_NONE;
            mode_q <= GPF_D_SP;
        end else if (launch) begin
            idx_q  <= index_vec;
            base_q <= base_addr;
            bv_q   <= base_valid;
            sc_q   <= scale_log2;
            disp_q <= disp;
            dsel_q <= gpf_disp_e'(disp_sel);
            mode_q <= gpf_mode_e'(mode);
        end
    end

    gpf_elem_sched #(.LANES(LANES)) u_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mode      (gpf_mode_e'(mode)),
        .mask_in   (mask_in),
        .req_ready (req_ready),
        .launch    (launch),
        .req_valid (req_valid),
        .elem      (elem),
        .busy      (busy),
        .done      (done),
        .mask_out  (mask_out)
    );

    gpf_lane_pick #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_pick (
        .idx_vec  (idx_q),
        .elem     (elem),
        .wide_idx (mode_q[1]),
        .idx_ext  (idx_ext)
    );

    gpf_addr_calc #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_addr (
        .base_addr  (base_q),
        .base_valid (bv_q),
        .idx_ext    (idx_ext),
        .scale_log2 (sc_q),
        .disp       (disp_q),
        .disp_sel   (dsel_q),
        .addr       (req_addr)
    );

    // Fixed hint: second-level cache, no ownership.
    assign req_level = GPF_HINT_L2;
    assign req_own   = 1'b0;

    // R9: a stalled address is held.
    p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> $stable(req_addr));
    // R6 / R7: 8-element modes never reach the upper lanes.
    p_half_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode_q != GPF_D_SP) |-> (elem < EW'(LANES / 2)));
endmodule

// File: tb/tb_gpf_prefetch_seq.sv
module tb_gpf_prefetch_seq;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [1:0]   mode = '0;
    logic [511:0] index_vec = '0;
    logic [63:0]  base_addr = '0;
    logic         base_valid = 1'b0;
    logic [1:0]   scale_log2 = '0;
    logic [31:0]  disp = '0;
    logic [1:0]   disp_sel = '0;
    logic [15:0]  mask_in = '0;
    logic         req_ready = 1'b0;
    logic         req_valid;
    logic [63:0]  req_addr;
    logic [1:0]   req_level;
    logic         req_own;
    logic         busy;
    logic         done;
    logic [15:0]  mask_out;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    gpf_prefetch_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .index_vec(index_vec), .base_addr(base_addr), .base_valid(base_valid),
        .scale_log2(scale_log2), .disp(disp), .disp_sel(disp_sel),
        .mask_in(mask_in), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_level(req_level), .req_own(req_own),
        .busy(busy), .done(done), .mask_out(mask_out)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Reference address for element j (R1-R5, R7).
    function automatic logic [63:0] ref_addr(input int j, input logic [1:0] md,
        input logic [511:0] iv, input logic [63:0] b, input logic bv,
        input logic [1:0] sc, input logic [31:0] d, input logic [1:0] ds);
        logic [63:0] ix, dx;
        if (md[1]) ix = iv[64*j +: 64];
        else       ix = {{32{iv[32*j+31]}}, iv[32*j +: 32]};
        case (ds)
            2'd1: dx = {{56{d[7]}}, d[7:0]};
            2'd2: dx = {{48{d[15]}}, d[15:0]};
            2'd3: dx = {{32{d[31]}}, d};
            default: dx = 64'd0;
        endcase
        return (bv ? b : 64'd0) + (ix << sc) + dx;
    endfunction

    // Run one operation; ready_pct sets the accept probability, poke_busy
    // pulses start with scrambled operands mid-operation (R13).
    task automatic run_op(input logic [1:0] md, input logic [511:0] iv,
        input logic [63:0] b, input logic bv, input logic [1:0] sc,
        input logic [31:0] d, input logic [1:0] ds, input logic [15:0] m,
        input int ready_pct, input bit poke_busy);
        int elems [16];
        int n = 0;
        int k = 0;
        int lim = (md == 2'd0) ? 16 : 8;
        for (int j = 0; j < lim; j++) if (m[j]) begin elems[n] = j; n++; end
        @(negedge clk);
        mode = md; index_vec = iv; base_addr = b; base_valid = bv;
        scale_log2 = sc; disp = d; disp_sel = ds; mask_in = m; start = 1'b1;
        req_ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        while (k < n) begin
            req_ready = (($urandom % 100) < ready_pct);
            if (poke_busy && k == 0) begin
                start = 1'b1; mask_in = ~m; base_addr = ~b; mode = ~md;
            end else begin
                start = 1'b0;
            end
            #1;
            check("R8 req_valid while pending", {63'd0, req_valid}, 64'd1);
            check("R1 req_addr", req_addr, ref_addr(elems[k], md, iv, b, bv, sc, d, ds));
            check("R10 hint", {61'd0, req_level, req_own}, {61'd0, 2'd1, 1'b0});
            check("R11 no early done", {63'd0, done}, 64'd0);
            if (req_ready) k++;
            @(negedge clk);
        end
        start = 1'b0;
        req_ready = 1'b0;
        #1;
        check("R11 done pulse", {63'd0, done}, 64'd1);
        check("R8 no extra request", {63'd0, req_valid}, 64'd0);
        check("R12 mask_out", {48'd0, mask_out}, {48'd0, m});
        @(negedge clk);
        #1;
        check("R11 done one cycle", {63'd0, done}, 64'd0);
    endtask

    function automatic logic [511:0] rand_vec();
        logic [511:0] v;
        for (int i = 0; i < 16; i++) v[32*i +: 32] = $urandom;
        return v;
    endfunction

    initial begin
        logic [511:0] iv;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        #1;
        check("reset busy", {63'd0, busy}, 64'd0);
        check("reset req_valid", {63'd0, req_valid}, 64'd0);
        check("reset done", {63'd0, done}, 64'd0);
        check("reset mask_out", {48'd0, mask_out}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R11: empty mask.
        run_op(2'd0, rand_vec(), 64'h1000, 1'b1, 2'd2, 32'h10, 2'd1, 16'h0000, 100, 0);
        // R5: mode 0, all 16 elements, full ready.
        run_op(2'd0, rand_vec(), 64'h8000_0000_0000_0000, 1'b1, 2'd3, 32'hFFFF_FF80, 2'd1, 16'hFFFF, 100, 0);
        // R6: mode 1 with only upper mask bits: nothing to issue.
        run_op(2'd1, rand_vec(), 64'h40, 1'b1, 2'd0, 32'd0, 2'd0, 16'hFF00, 100, 0);
        // R6: mode 1 full mask uses low 8 lanes.
        run_op(2'd1, rand_vec(), 64'h2000, 1'b1, 2'd1, 32'h8000, 2'd2, 16'hFFFF, 70, 0);
        // R7: 64-bit indices, negative index, wrap.
        iv = rand_vec();
        iv[63:0] = 64'hFFFF_FFFF_FFFF_FFF0;
        run_op(2'd2, iv, 64'h0000_0000_0000_0008, 1'b1, 2'd3, 32'h8000_0000, 2'd3, 16'hF0FF, 100, 0);
        run_op(2'd3, rand_vec(), 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 2'd2, 32'h7F, 2'd1, 16'h00A5, 50, 0);
        // R4: absent base; R2: each scale; R3: each displacement width.
        for (int s = 0; s < 4; s++)
            run_op(2'd0, rand_vec(), 64'hDEAD_BEEF_0000_0000, 1'b0, s[1:0], 32'hFFFF_8001, s[1:0], 16'h8001, 60, 0);
        // R9: heavy stall.
        run_op(2'd0, rand_vec(), 64'h1234, 1'b1, 2'd1, 32'h4, 2'd3, 16'h5A5A, 15, 0);
        // R13: start while busy.
        run_op(2'd0, rand_vec(), 64'h5000, 1'b1, 2'd0, 32'h0, 2'd0, 16'h0C03, 30, 1);
        // Random operations.
        for (int t = 0; t < 40; t++)
            run_op($urandom % 4, rand_vec(), {$urandom, $urandom}, $urandom % 2,
                   $urandom % 4, $urandom, $urandom % 4, $urandom % 65536,
                   20 + ($urandom % 81), ($urandom % 4) == 0);

        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule